// File: doc/BRIEF.md
# Symbol-Driven Rule 110 Cell Array

This block holds a one-dimensional row of two-state cells and evolves them under elementary cellular automaton rule 110. It has no start, load or step ports: one 8-bit symbol stream, qualified by a valid strobe, does everything. Letter symbols name individual cells and force them alive. The digit symbols `0` and `1` are instructions that advance the whole row by one generation.

Two configuration inputs shape the evolution. The first picks the stepping scheme: a `1` then `0` pair per generation, or a single `0` per generation. The second picks ring wrap-around or fixed edge values, and each edge value can be set on its own. After an instruction, the next letter wipes the row before it seeds its own cell. This lets a host reseed the array mid-stream by simply sending new labels.

Cell 0 is the leftmost cell. The left neighbour of cell i is cell i-1.

Top module: `ca110_stream`

## Requirements
- R1: While reset is asserted, and after it is released, every cell is dead, every dead indication is high and `gen_done` is low.
- R2: Cell i has one label symbol. For i<26 it is ASCII 'a'+i (0x61+i). For 26≤i<52 it is 'A'+(i-26) (0x41+i-26). An accepted label marks its cell alive on the next clock. A label whose index is NCELLS or more marks no cell.
- R3: If a label is the first label after an instruction symbol ('0' = 0x30 or '1' = 0x31), every cell is cleared before that label sets its own cell. Later labels in the same run only add cells.
- R4: With `single_step` low, a '0' that is accepted while a '1' is pending advances one generation. A '1' becomes pending when it is accepted. Repeated '1's keep it pending. Any '0' or any label clears it.
- R5: With `single_step` high, every accepted '0' advances one generation, and an accepted '1' never advances.
- R6: On a step, each cell takes the value of rule 110 applied to (left, centre, right). Patterns 111..000 map to 0,1,1,0,1,1,1,0. All cells update at the same time from the previous generation.
- R7: With `wrap` high, the left neighbour of cell 0 is cell NCELLS-1, and the right neighbour of cell NCELLS-1 is cell 0.
- R8: With `wrap` low, cell 0 sees `left_edge` as its left neighbour, and cell NCELLS-1 sees `right_edge` as its right neighbour.
- R9: The following have no effect on the cells or on `gen_done`: a clock with `sym_valid` low, any symbol that is neither a label nor '0' or '1', and a '0' with no pending '1' in two-symbol mode.
- R10: `gen_done` is high for exactly the one cycle in which the new generation first appears on `alive`, which is the clock after the stepping '0'.
- R11: For every cell, exactly one of `alive[i]` and `dead[i]` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Symbol on `sym` is accepted this clock |
| sym | input | 8 | Input symbol (ASCII) |
| single_step | input | 1 | 1: each '0' steps; 0: '1' then '0' steps |
| wrap | input | 1 | 1: ring boundary; 0: constant edges |
| left_edge | input | 1 | Fixed left neighbour of cell 0 when `wrap` is low |
| right_edge | input | 1 | Fixed right neighbour of the last cell when `wrap` is low |
| alive | output | NCELLS | Alive indication per cell |
| dead | output | NCELLS | Dead indication per cell |
| gen_done | output | 1 | One-cycle pulse when a new generation appears |

## Verification
The bench drives edge cells against ring and fixed boundaries. A design that wrapped the wrong way, or ignored one edge value, would show a wrong end cell after a single step from a lone seed. It sends a '0' with no '1' before it, stray symbols, repeated '1's and labels between '1' and '0'. A design with a loose pending-'1' rule would step when it should not, or miss a step. It reseeds after instructions, including with a label that has no cell. A design that kept old cells, or cleared on every label, would show a stale or a shrunken row. Mode and boundary inputs change while the stream runs, and a cycle-exact model is compared on every clock.

// File: rtl/ca110_stream.sv
module ca110_stream #(
  parameter int NCELLS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [7:0]        sym,
  input  logic              single_step,
  input  logic              wrap,
  input  logic              left_edge,
  input  logic              right_edge,
  output logic [NCELLS-1:0] alive,
  output logic [NCELLS-1:0] dead,
  output logic              gen_done
);

  localparam logic [7:0] SYM_ZERO = 8'h30;
  localparam logic [7:0] SYM_ONE  = 8'h31;

  logic              pend_one, after_instr;
  logic              is_lower, is_upper, is_label, is_zero, is_one, step;
  logic [7:0]        lbl_idx;
  logic [NCELLS-1:0] lbl_mask, nxt;
  logic [NCELLS+1:0] ext;

  assign is_lower = (sym >= 8'h61) && (sym <= 8'h7a);
  assign is_upper = (sym >= 8'h41) && (sym <= 8'h5a);
  assign is_label = is_lower || is_upper;
  assign is_zero  = (sym == SYM_ZERO);
  assign is_one   = (sym == SYM_ONE);
  assign lbl_idx  = is_lower ? sym - 8'h61 : sym - 8'h41 + 8'd26;
  assign step     = sym_valid && is_zero && (single_step || pend_one);

  assign ext = {wrap ? alive[0] : right_edge, alive, wrap ? alive[NCELLS-1] : left_edge};

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    logic l, c, r;
    assign l = ext[i];
    assign c = ext[i+1];
    assign r = ext[i+2];
    assign nxt[i]      = (c & ~l) | (c & ~r) | (~c & r);
    assign lbl_mask[i] = is_label && (lbl_idx == 8'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive       <= '0;
      dead        <= '1;
      pend_one    <= 1'b0;
      after_instr <= 1'b0;
      gen_done    <= 1'b0;
    end else begin
      gen_done <= step;
      if (sym_valid) begin
        if (is_label) begin
          alive       <= after_instr ? lbl_mask : (alive | lbl_mask);
          dead        <= after_instr ? ~lbl_mask : (dead & ~lbl_mask);
          after_instr <= 1'b0;
          pend_one    <= 1'b0;
        end else if (is_one) begin
          after_instr <= 1'b1;
          pend_one    <= ~single_step;
        end else if (is_zero) begin
          after_instr <= 1'b1;
          pend_one    <= 1'b0;
          if (step) begin
            alive <= nxt;
            dead  <= ~nxt;
          end
        end
      end
    end
  end

  p_alive_dead_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alive ^ dead) == {NCELLS{1'b1}});

  p_done_after_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |-> $past(sym_valid && sym == SYM_ZERO));

  p_one_never_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym == SYM_ONE) |=> (!gen_done && $stable(alive)));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(alive) && !gen_done));

  p_label_sets_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && is_label) |=> ((alive & $past(lbl_mask)) == $past(lbl_mask)));

endmodule

// File: tb/ca110_stream_test.sv
`timescale 1ns/1ps
module ca110_stream_test;
  localparam int N = 40;
  localparam logic [7:0] RULE = 8'd110;

  logic clk = 0, rst_n = 0, sym_valid = 0, single_step = 0, wrap = 0;
  logic left_edge = 0, right_edge = 0;
  logic [7:0] sym = 8'h00;
  logic [N-1:0] alive, dead;
  logic gen_done;

  int checks = 0, fails = 0;
  logic [N-1:0] m_alive = '0;
  bit m_pend = 0, m_after = 0, m_done = 0;

  always #2.5 clk = ~clk;

  ca110_stream #(.NCELLS(N)) uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .single_step(single_step), .wrap(wrap), .left_edge(left_edge),
    .right_edge(right_edge), .alive(alive), .dead(dead), .gen_done(gen_done));

  task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check_vec(tag, alive, m_alive);
    check_vec("R11", dead, ~m_alive);
    checks++;
    if (gen_done !== m_done) begin
      fails++;
      $display("FAIL R10 (%s): gen_done actual %b expected %b", tag, gen_done, m_done);
    end
  endtask

  function automatic logic [N-1:0] evolve(input logic [N-1:0] cur);
    logic [N-1:0] res;
    for (int i = 0; i < N; i++) begin
      logic l, r;
      l = (i == 0) ? (wrap ? cur[N-1] : left_edge) : cur[i-1];
      r = (i == N-1) ? (wrap ? cur[0] : right_edge) : cur[i+1];
      res[i] = RULE[{l, cur[i], r}];
    end
    return res;
  endfunction

  task automatic model_clock();
    bit stp, lab;
    int idx;
    stp = sym_valid && sym == "0" && (single_step || m_pend);
    lab = 0; idx = 0;
    if (sym_valid) begin
      if (sym >= "a" && sym <= "z") begin lab = 1; idx = sym - "a"; end
      else if (sym >= "A" && sym <= "Z") begin lab = 1; idx = sym - "A" + 26; end
      if (lab) begin
        if (m_after) m_alive = '0;
        if (idx < N) m_alive[idx] = 1'b1;
        m_after = 0; m_pend = 0;
      end else if (sym == "1") begin
        m_after = 1; m_pend = !single_step;
      end else if (sym == "0") begin
        m_after = 1;
        if (stp) m_alive = evolve(m_alive);
        m_pend = 0;
      end
    end
    m_done = stp;
  endtask

  task automatic send(input logic v, input logic [7:0] s, input string tag);
    sym_valid = v; sym = s;
    model_clock();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    // R2 seeding, R6 stepping in two-symbol mode (R4)
    send(1, "a", "R2"); send(1, "c", "R2"); send(1, "m", "R2"); send(1, "z", "R2");
    for (int g = 0; g < 3; g++) begin send(1, "1", "R4"); send(1, "0", "R4 R6"); end
    // R3 reinit
    send(1, "k", "R3"); send(1, "y", "R3 add");
    send(1, "1", "R4"); send(1, "1", "R4 repeat"); send(1, "0", "R4");
    // R9 ignored stimuli
    send(1, "0", "R9 lone zero"); send(1, "#", "R9 junk"); send(1, "7", "R9 digit");
    send(0, "0", "R9 invalid"); send(1, "1", "R4"); send(1, "%", "R9 junk keeps pend");
    send(1, "0", "R4");
    send(1, "1", "R4"); send(1, "b", "R4 label cancels"); send(1, "0", "R9 cancelled");
    // hand values: R6 lone seed, constant dead edges
    send(1, "1", "R3"); send(1, "Z", "R2 no cell"); check_vec("R3 cleared", alive, '0);
    send(1, "b", "R2"); send(1, "1", "R4"); send(1, "0", "R6");
    check_vec("R6 hand", alive, N'(3));
    // R8 right edge alive from empty row
    send(1, "1", "R3"); send(1, "Z", "R3");
    right_edge = 1; send(1, "1", "R8"); send(1, "0", "R8");
    check_vec("R8 hand", alive, N'(1) << (N-1));
    right_edge = 0; left_edge = 1;
    send(1, "1", "R8"); send(1, "0", "R8 left");
    // R7 periodic from cell 0
    wrap = 1; send(1, "a", "R3"); send(1, "1", "R7"); send(1, "0", "R7");
    check_vec("R7 hand", alive, (N'(1) << (N-1)) | N'(1));
    // R5 single step mode
    single_step = 1;
    send(1, "1", "R5 one"); send(1, "0", "R5"); send(1, "0", "R5 back to back");
    send(1, "0", "R5"); send(1, "1", "R5 one");
    // mixed random stream
    for (int k = 0; k < 600; k++) begin
      int p;
      if (k % 50 == 0) begin
        single_step = $urandom_range(0, 1); wrap = $urandom_range(0, 1);
        left_edge = $urandom_range(0, 1); right_edge = $urandom_range(0, 1);
      end
      p = $urandom_range(0, 9);
      case (p)
        0: send(1, 8'("a" + $urandom_range(0, 25)), "R2 R3");
        1: send(1, 8'("A" + $urandom_range(0, 25)), "R2 R3");
        2, 3, 4: send(1, "1", "R4 R5");
        5, 6, 7: send(1, "0", "R6 R7 R8");
        8: send(1, "?", "R9");
        default: send(0, "0", "R9");
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule